// File: doc/BRIEF.md
# Programmable Delay and One-Shot Pulse Generator

This block is a clock-tick model of a programmable timing element. A single-bit waveform enters on `sig_in` and an 8-bit `setting` chooses a delay in clock ticks. Every sampled input value goes into a shift register deep enough for the longest delay. The delayed output is taken from that register, so an input may toggle many times inside the delay window and every edge still comes out. Rising and falling edges see the same delay.

The mode input `alt_mode` decides what the two outputs mean. With `alt_mode` low, `dly_out` carries the input delayed by `BASE_DLY + setting` ticks with the same polarity. `aux_out` carries a reference copy delayed by `BASE_DLY + 1` ticks, which is one tick later than the zero-setting delay. With `alt_mode` high, `dly_out` carries the inverted copy with the same programmed delay. `aux_out` then becomes a one-shot pulse that cannot be retriggered. A rising input edge starts the pulse `BASE_DLY` ticks later, and the pulse stays high for `setting` ticks.

The one-shot is a three-state machine. IDLE waits for a trigger. The transition IDLE to WAIT (trigger) happens on a rising input edge while the setting is non-zero, and the width is captured at that point. WAIT counts out the base offset, and the transition WAIT to HIGH (launch) happens when that count reaches zero. HIGH holds the pulse for the captured width, and the transition HIGH to IDLE (expire) happens when the width count reaches zero. Dropping `alt_mode` forces the transition from any state to IDLE (abort).

Top module: `tapped_delay_timer`

## Requirements
- R1: An active-low `rst_n` drives both outputs low, clears the one-shot to IDLE and clears the whole input history to low. After reset, no value sampled before reset can reach an output.
- R2: With `alt_mode` low, the value of `sig_in` sampled at clock edge k appears on `dly_out` after edge k + BASE_DLY + setting, with the same polarity. This holds for both rising and falling edges.
- R3: A setting of 0 still gives a delay of BASE_DLY ticks (at least one tick) on `dly_out`.
- R4: With `alt_mode` low, `aux_out` shows the input sampled at edge k after edge k + BASE_DLY + 1. With a setting of 0, `aux_out` therefore trails `dly_out` by exactly one tick.
- R5: With the setting at 255 and the input toggling many times within the delay window, every input edge is reproduced at the output.
- R6: A new setting selects its tap at the next clock edge. Changing the setting on every cycle gives, on every cycle, the tap chosen by that cycle's setting.
- R7: With `alt_mode` high, `dly_out` is the logical inverse of the R2 output, with the same delay.
- R8: With `alt_mode` high, a rising edge of `sig_in` (1 sampled at edge k, 0 at edge k-1) from IDLE with a non-zero setting W drives `aux_out` high after edge k + BASE_DLY. `aux_out` stays high for exactly W ticks.
- R9: Rising edges sampled while the one-shot is in WAIT or HIGH are ignored. They neither restart nor stretch the pulse, and the machine never goes from HIGH straight back to WAIT.
- R10: A rising edge with a setting of 0 produces no pulse, and the one-shot stays in IDLE.
- R11: Lowering `alt_mode` aborts any pulse: the machine returns to IDLE, and from the next tick `aux_out` shows the R4 reference output again.
- R12: The one-shot moves only along IDLE to WAIT, WAIT to HIGH and HIGH to IDLE, plus the abort to IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick is the delay resolution |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Waveform to be delayed or used as a trigger |
| setting | input | SET_W | Delay in ticks, or pulse width in ticks in one-shot mode |
| alt_mode | input | 1 | 0: delayed copy plus reference; 1: inverted copy plus one-shot |
| dly_out | output | 1 | Programmed delayed copy, inverted when alt_mode is 1 |
| aux_out | output | 1 | Reference delayed copy, or the one-shot pulse when alt_mode is 1 |

## Verification
The bench builds the block with BASE_DLY = 3 and SET_W = 8. With these values the WAIT state really counts down over several ticks, and the full 255-tick delay can be reached, so the deepest tap and the reference tap are both exercised. Three delay settings are chosen so that inputs toggle many times inside the window, and the one-shot widths are chosen both longer and shorter than the gap between triggers. This reaches the ignored-retrigger case and the back-to-back accepted-trigger case. A reset in the middle of a run, while the history holds ones, shows that the history is cleared.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
    typedef enum logic [1:0] {
        OS_IDLE = 2'd0,
        OS_WAIT = 2'd1,
        OS_HIGH = 2'd2
    } os_state_e;
endpackage

// File: rtl/tdl_history.sv
module tdl_history #(
    parameter int DEPTH = 257
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [DEPTH-1:0] hist
);
    // hist[j] holds the input sampled j edges before the most recent one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[DEPTH-2:0], din};
    end
endmodule

// File: rtl/tdl_tap.sv
module tdl_tap #(
    parameter int DEPTH    = 257,
    parameter int SET_W    = 8,
    parameter int BASE_DLY = 2
) (
    input  logic [DEPTH-1:0] hist,
    input  logic [SET_W-1:0] setting,
    output logic             tap
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int NTAP  = 1 << SET_W;

    // One tap per setting value; the registered output adds the last tick
    logic [NTAP-1:0] taps;
    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        assign taps[g] = hist[BASE_DLY - 1 + g];
    end

    logic [IDX_W-1:0] unused_idx;
    assign unused_idx = IDX_W'(setting);
    assign tap = taps[setting];
endmodule

// File: rtl/tdl_oneshot.sv
module tdl_oneshot
    import tdl_pkg::*;
#(
    parameter int SET_W    = 8,
    parameter int BASE_DLY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             rise,
    input  logic [SET_W-1:0] width,
    output logic             pulse,
    output os_state_e        state
);
    localparam int BW    = $clog2(BASE_DLY + 1);
    localparam int CNT_W = (SET_W > BW) ? SET_W : BW;

    os_state_e        nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [SET_W-1:0] wid, wid_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OS_IDLE;
            cnt   <= '0;
            wid   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            wid   <= wid_nxt;
        end
    end

    // Transitions: trigger, launch, expire, abort
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        wid_nxt = wid;
        if (!enable) begin
            nxt     = OS_IDLE;
            cnt_nxt = '0;
        end else begin
            unique case (state)
                OS_IDLE: begin
                    if (rise && (width != '0)) begin
                        nxt     = OS_WAIT;
                        cnt_nxt = CNT_W'(BASE_DLY - 1);
                        wid_nxt = width;
                    end
                end
                OS_WAIT: begin
                    if (cnt == '0) begin
                        nxt     = OS_HIGH;
                        cnt_nxt = CNT_W'(wid) - CNT_W'(1);
                    end else begin
                        cnt_nxt = cnt - CNT_W'(1);
                    end
                end
                OS_HIGH: begin
                    if (cnt == '0) nxt = OS_IDLE;
                    else           cnt_nxt = cnt - CNT_W'(1);
                end
                default: nxt = OS_IDLE;
            endcase
        end
    end

    // Output process
    always_comb begin
        pulse = (state == OS_HIGH);
    end
endmodule

// File: rtl/tapped_delay_timer.sv
module tapped_delay_timer
    import tdl_pkg::*;
#(
    parameter int BASE_DLY = 2,
    parameter int SET_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic [SET_W-1:0] setting,
    input  logic             alt_mode,
    output logic             dly_out,
    output logic             aux_out
);
    localparam int DEPTH   = BASE_DLY + (1 << SET_W) - 1;
    localparam int REF_TAP = BASE_DLY;

    logic [DEPTH-1:0] hist;
    logic             tap;
    logic             rise;
    logic             pulse;
    os_state_e        os_state;
    logic             main_q, ref_q, mode_q;

    tdl_history #(.DEPTH(DEPTH)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sig_in),
        .hist  (hist)
    );

    tdl_tap #(.DEPTH(DEPTH), .SET_W(SET_W), .BASE_DLY(BASE_DLY)) u_tap (
        .hist    (hist),
        .setting (setting),
        .tap     (tap)
    );

    assign rise = sig_in & ~hist[0];

    tdl_oneshot #(.SET_W(SET_W), .BASE_DLY(BASE_DLY)) u_os (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (alt_mode),
        .rise   (rise),
        .width  (setting),
        .pulse  (pulse),
        .state  (os_state)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= 1'b0;
            ref_q  <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            main_q <= tap ^ alt_mode;
            ref_q  <= hist[REF_TAP];
            mode_q <= alt_mode;
        end
    end

    assign dly_out = main_q;
    assign aux_out = mode_q ? pulse : ref_q;
endmodule

// File: rtl/tdl_checker.sv
module tdl_checker
    import tdl_pkg::*;
#(
    parameter int SET_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SET_W-1:0] setting,
    input logic             alt_mode,
    input logic             dly_out,
    input logic             aux_out,
    input os_state_e        os_state
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!dly_out && !aux_out));

    p_ref_trails_main_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(alt_mode) && !$past(alt_mode, 2) && ($past(setting, 2) == '0))
        |-> (aux_out == $past(dly_out)));

    p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_mode |=> (os_state == OS_IDLE));

    p_launch_from_wait_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((os_state == OS_HIGH) && ($past(os_state) != OS_HIGH))
        |-> ($past(os_state) == OS_WAIT));

    p_no_retrigger_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((os_state == OS_WAIT) && ($past(os_state) != OS_WAIT))
        |-> ($past(os_state) == OS_IDLE));

    p_zero_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((os_state == OS_IDLE) && (setting == '0)) |=> (os_state == OS_IDLE));
endmodule

bind tapped_delay_timer tdl_checker #(.SET_W(SET_W)) u_tdl_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .setting  (setting),
    .alt_mode (alt_mode),
    .dly_out  (dly_out),
    .aux_out  (aux_out),
    .os_state (os_state)
);

// File: tb/test_tapped_delay_timer.sv
module test_tapped_delay_timer;
    localparam int PERIOD = 10;
    localparam int BASE   = 3;
    localparam int SW     = 8;
    localparam int HM     = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sig_in = 1'b0;
    logic          alt_mode = 1'b0;
    logic [SW-1:0] setting = '0;
    logic          dly_out, aux_out;

    always #(PERIOD / 2) clk = ~clk;

    tapped_delay_timer #(.BASE_DLY(BASE), .SET_W(SW)) i_tapped_delay_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_in   (sig_in),
        .setting  (setting),
        .alt_mode (alt_mode),
        .dly_out  (dly_out),
        .aux_out  (aux_out)
    );

    // Vector fields: {tag index[3:0], alt, setting[7:0], pattern[15:0]}
    localparam logic [28:0] VEC [8] = '{
        {4'd0, 1'b0, 8'd0,   16'h00FF},
        {4'd1, 1'b0, 8'd5,   16'h0F0F},
        {4'd2, 1'b0, 8'd255, 16'hA5C3},
        {4'd3, 1'b1, 8'd37,  16'h3C3C},
        {4'd4, 1'b1, 8'd3,   16'h0101},
        {4'd5, 1'b1, 8'd20,  16'h0505},
        {4'd6, 1'b1, 8'd0,   16'h00F0},
        {4'd7, 1'b0, 8'd128, 16'h1248}
    };

    function automatic string tag_of(input int t);
        case (t)
            0: return "R3 zero setting / R4 reference";
            1: return "R2 short delay";
            2: return "R5 full range many edges";
            3: return "R7 inverted copy";
            4: return "R8 one-shot width";
            5: return "R9 retrigger ignored";
            6: return "R10 zero width";
            default: return "R2 mid delay";
        endcase
    endfunction

    int checks = 0, failures = 0;
    int k = HM;
    bit hv [HM];
    bit os_act = 0;
    int os_k = 0, os_w = 0;
    int mism = 0, f_edge = 0;
    bit f_act_m, f_exp_m, f_act_a, f_exp_a;

    task automatic step(input bit d, input logic [SW-1:0] s, input bit a, input bit chk);
        bit rise, em, ea;
        sig_in = d; setting = s; alt_mode = a;
        @(posedge clk);
        k++;
        hv[k % HM] = d;
        rise = d && !hv[(k - 1) % HM];
        if (!a || !rst_n) os_act = 0;
        else if (!(os_act && k <= os_k + BASE + os_w) && rise && s != 0) begin
            os_act = 1; os_k = k; os_w = int'(s);
        end
        em = hv[(k - BASE - int'(s)) % HM] ^ a;
        ea = a ? (os_act && k >= os_k + BASE && k < os_k + BASE + os_w)
               : hv[(k - BASE - 1) % HM];
        #1;
        if (chk && (dly_out !== em || aux_out !== ea)) begin
            if (mism == 0) begin
                f_edge = k; f_act_m = dly_out; f_exp_m = em; f_act_a = aux_out; f_exp_a = ea;
            end
            mism++;
        end
    endtask

    task automatic close_check(input string tag);
        checks++;
        if (mism != 0) begin
            failures++;
            $display("FAIL %s: %0d bad cycles, first at edge %0d actual main=%b aux=%b expected main=%b aux=%b",
                     tag, mism, f_edge, f_act_m, f_act_a, f_exp_m, f_exp_a);
        end
        mism = 0;
    endtask

    task automatic chk1(input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        sig_in = 0; alt_mode = 0;
        rst_n = 0;
        foreach (hv[i]) hv[i] = 0;
        os_act = 0;
        #1;
        chk1("R1 outputs low in reset (main)", dly_out, 1'b0);
        chk1("R1 outputs low in reset (aux)", aux_out, 1'b0);
        for (int i = 0; i < 3; i++) step(0, setting, 0, 0);
        rst_n = 1;
    endtask

    initial begin
        #(PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();

        // Table of stimulus vectors, each checked cycle by cycle against the model
        for (int v = 0; v < 8; v++) begin
            for (int c = 0; c < 300; c++)
                step(VEC[v][c % 16], VEC[v][23:16], VEC[v][24], 1);
            close_check(tag_of(int'(VEC[v][28:25])));
        end

        // R6: setting changes every cycle
        for (int c = 0; c < 200; c++)
            step(((c / 3) % 2) == 1, (c % 2) ? 8'd9 : 8'd4, 0, 1);
        close_check("R6 setting switch per cycle");

        // R1: reset mid-run with ones in history, then long delay with low input
        for (int c = 0; c < 40; c++) step(1, 8'd255, 0, 1);
        close_check("R2 hold before reset");
        do_reset();
        for (int c = 0; c < 270; c++) step(0, 8'd255, 0, 1);
        close_check("R1 history cleared by reset");

        // R8/R12 exact launch: rise at one edge, pulse of 4 ticks
        for (int c = 0; c < 10; c++) step(0, 8'd4, 1, 1);
        step(1, 8'd4, 1, 1);
        for (int c = 1; c < BASE; c++) begin
            step(1, 8'd4, 1, 1);
            chk1("R12 still waiting", aux_out, 1'b0);
        end
        step(1, 8'd4, 1, 1);
        chk1("R8 launch after base offset", aux_out, 1'b1);
        for (int c = 1; c < 4; c++) step(0, 8'd4, 1, 1);
        chk1("R8 last high tick", aux_out, 1'b1);
        step(0, 8'd4, 1, 1);
        chk1("R8 pulse ends after width", aux_out, 1'b0);
        close_check("R12 launch sequence model");

        // R11: abort a long pulse by lowering the mode
        for (int c = 0; c < 6; c++) step(0, 8'd50, 1, 1);
        step(1, 8'd50, 1, 1);
        for (int c = 0; c < 12; c++) step(1, 8'd50, 1, 1);
        chk1("R11 pulse active before abort", aux_out, 1'b1);
        step(1, 8'd50, 0, 1);
        chk1("R11 aux shows reference after abort", aux_out, hv[(k - BASE - 1) % HM]);
        for (int c = 0; c < 60; c++) step(c[2], 8'd50, 0, 1);
        close_check("R11 abort then reference");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule